// File: doc/BRIEF.md
# Message-Signaled Interrupt File

This block is the interrupt file of one hart at one privilege level. Devices and other harts never wire interrupts to it. They write an identity number into a doorbell word in the file's page, and that sets the identity's pending bit. Each identity also has an enable bit. The block keeps a delivery switch and a priority threshold. From these it derives one winning identity, where a lower number is more urgent, and an interrupt request to the hart.

Software reaches all internal state through an indirect window. A 12-bit select picks an internal register. A data port then reads it combinationally, or on a write strobe applies a plain write, a bit-set or a bit-clear. The top-identity register reports the winner. Any write-type access to it is a swap: the data port returns the current winner in that cycle, and the winner's pending bit clears at the same clock edge. Software claims interrupts by swapping until it reads zero.

The number of identities `NUM_IDS` is a parameter between 63 and 2047. It must be one less than a multiple of 64. The default is 63.

Top module: `msi_file`

## Requirements
- R1: Identity 0 does not exist. Bit 0 of pending word 0 and of enable word 0 always reads 0, whatever is written to it.
- R2: On `db_we`, a 32-bit value at byte offset 0x000 is taken as a little-endian identity number. At offset 0x004 the same number is taken byte-reversed: byte 0 of `db_data` is the most significant byte. The matching pending bit sets at the next clock edge. Writes at any other offset, and values of 0 or above `NUM_IDS`, change nothing.
- R3: Select 0x070 is the delivery register, held in bit 0. A value of 1 allows delivery and 0 blocks it.
- R4: Select 0x072 is the threshold register, held in bits 10:0. When it is nonzero, only identities numerically below it are eligible. When it is zero, no threshold applies.
- R5: Select 0x080+k is pending word k and select 0x0C0+k is enable word k, for k < (NUM_IDS+1)/32. Bit j of word k belongs to identity 32k+j.
- R6: When `ind_we` is high, `ind_op` selects how the selected register changes. A value of 01 ORs in `ind_wdata` (bit-set). A value of 10 clears the bits set in `ind_wdata` (bit-clear). A value of 00 or 11 stores `ind_wdata` (plain write).
- R7: Select 0x076 is the top-identity register. An identity is eligible when it is pending, enabled and passes the threshold. The register reads {5'b0, id, 5'b0, id}: the lowest eligible identity in bits 26:16, and its priority, equal to the identity, in bits 10:0. It reads 0 when no identity is eligible.
- R8: Any write-type access to select 0x076 returns the current winner on `ind_rdata` in that cycle and clears the winner's pending bit at that clock edge. If a doorbell for the same identity arrives in the same cycle, the bit stays set.
- R9: `irq` is high exactly when delivery is on and at least one identity is eligible. It falls in the cycle after the last eligible identity is claimed or disabled.
- R10: Selects other than those in R3, R4, R5 and R7 read as 0, and writes to them change no state.
- R11: After reset, all pending and enable bits, the delivery register and the threshold are 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_we | input | 1 | Doorbell write strobe |
| db_addr | input | 12 | Byte offset of the doorbell write within the page |
| db_data | input | 32 | Doorbell write data (identity number) |
| ind_sel | input | 12 | Indirect register select |
| ind_we | input | 1 | Indirect write strobe |
| ind_op | input | 2 | Write kind: 00 write, 01 set, 10 clear, 11 write |
| ind_wdata | input | 32 | Indirect write data |
| ind_rdata | output | 32 | Selected register contents (combinational) |
| irq | output | 1 | Interrupt request to the hart |

## Verification
The arbitration is tried with several identities pending at once in different arrival orders. Claiming them one by one shows that the lowest number wins and that each swap removes exactly one identity. Doorbells in both byte orders, at a wrong offset, and with the out-of-range values 0 and 64 show the decode and its rejections. Masking through enable bit-clear, thresholds just at and just above a pending identity, and toggling delivery separate the three eligibility gates from one another and from `irq`. A doorbell that collides with a swap of the same identity fixes the set-over-clear order.

// File: rtl/msi_file.sv
module msi_file #(
  parameter int NUM_IDS = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        db_we,
  input  logic [11:0] db_addr,
  input  logic [31:0] db_data,
  input  logic [11:0] ind_sel,
  input  logic        ind_we,
  input  logic [1:0]  ind_op,
  input  logic [31:0] ind_wdata,
  output logic [31:0] ind_rdata,
  output logic        irq
);
  localparam int NB  = NUM_IDS + 1;
  localparam int NW  = NB / 32;
  localparam int IDW = $clog2(NB);

  localparam logic [11:0] SEL_DELIV = 12'h070;
  localparam logic [11:0] SEL_THR   = 12'h072;
  localparam logic [11:0] SEL_TOP   = 12'h076;
  localparam logic [11:0] SEL_PEND  = 12'h080;
  localparam logic [11:0] SEL_ENAB  = 12'h0C0;

  logic [NB-1:0]  pend, enab, pend_nx, enab_nx, elig;
  logic           deliv, deliv_nx, any;
  logic [10:0]    thr, thr_nx;
  logic [IDW-1:0] win;
  logic [31:0]    top, db_id;
  logic           db_hit;

  function automatic logic [31:0] upd(input logic [31:0] old, input logic [31:0] wd,
                                      input logic [1:0] op);
    case (op)
      2'b01:   upd = old | wd;
      2'b10:   upd = old & ~wd;
      default: upd = wd;
    endcase
  endfunction

  // doorbell decode, second word is byte-reversed
  assign db_id  = (db_addr == 12'h004) ?
                  {db_data[7:0], db_data[15:8], db_data[23:16], db_data[31:24]} : db_data;
  assign db_hit = db_we && (db_addr == 12'h000 || db_addr == 12'h004) &&
                  db_id != 32'd0 && db_id <= 32'(NUM_IDS);

  always_comb begin
    for (int i = 0; i < NB; i++)
      elig[i] = pend[i] & enab[i] & ((thr == 11'd0) || (11'(i) < thr));
  end

  always_comb begin
    win = '0;
    for (int i = NB - 1; i > 0; i--)
      if (elig[i]) win = IDW'(i);
  end

  assign any = |elig;
  assign top = any ? {5'b0, 11'(win), 5'b0, 11'(win)} : 32'd0;
  assign irq = deliv & any;

  always_comb begin
    ind_rdata = 32'd0;
    case (ind_sel)
      SEL_DELIV: ind_rdata = {31'd0, deliv};
      SEL_THR:   ind_rdata = {21'd0, thr};
      SEL_TOP:   ind_rdata = top;
      default:   ind_rdata = 32'd0;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (ind_sel == SEL_PEND + 12'(w)) ind_rdata = pend[w*32 +: 32];
      if (ind_sel == SEL_ENAB + 12'(w)) ind_rdata = enab[w*32 +: 32];
    end
  end

  always_comb begin
    pend_nx  = pend;
    enab_nx  = enab;
    deliv_nx = deliv;
    thr_nx   = thr;
    if (ind_we) begin
      if (ind_sel == SEL_DELIV) deliv_nx = upd({31'd0, deliv}, ind_wdata, ind_op)[0];
      if (ind_sel == SEL_THR)   thr_nx   = upd({21'd0, thr}, ind_wdata, ind_op)[10:0];
      if (ind_sel == SEL_TOP && any) pend_nx[win] = 1'b0;
      for (int w = 0; w < NW; w++) begin
        if (ind_sel == SEL_PEND + 12'(w))
          pend_nx[w*32 +: 32] = upd(pend[w*32 +: 32], ind_wdata, ind_op);
        if (ind_sel == SEL_ENAB + 12'(w))
          enab_nx[w*32 +: 32] = upd(enab[w*32 +: 32], ind_wdata, ind_op);
      end
    end
    if (db_hit) pend_nx[db_id[IDW-1:0]] = 1'b1;
    pend_nx[0] = 1'b0;
    enab_nx[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      enab  <= '0;
      deliv <= 1'b0;
      thr   <= 11'd0;
    end else begin
      pend  <= pend_nx;
      enab  <= enab_nx;
      deliv <= deliv_nx;
      thr   <= thr_nx;
    end
  end
endmodule

// File: rtl/msi_file_chk.sv
module msi_file_chk #(
  parameter int NUM_IDS = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_we,
  input logic [11:0]       db_addr,
  input logic [31:0]       db_data,
  input logic [11:0]       ind_sel,
  input logic              ind_we,
  input logic [31:0]       ind_rdata,
  input logic              irq,
  input logic              deliv,
  input logic [10:0]       thr,
  input logic [NUM_IDS:0]  pend
);
  localparam int IDW = $clog2(NUM_IDS + 1);

  a_r9_irq_needs_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> deliv);

  a_r9_irq_on_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (deliv && ind_sel == 12'h076 && ind_rdata != 32'd0) |-> irq);

  a_r7_top_format: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_sel == 12'h076) |-> (ind_rdata[10:0] == ind_rdata[26:16] &&
                              ind_rdata[15:11] == 5'd0 && ind_rdata[31:27] == 5'd0));

  a_r4_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_sel == 12'h076 && thr != 11'd0 && ind_rdata != 32'd0) |-> (ind_rdata[26:16] < thr));

  a_r8_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_we && ind_sel == 12'h076 && ind_rdata != 32'd0 && !db_we)
      |=> !pend[$past(ind_rdata[16 +: IDW])]);

  a_r2_doorbell_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (db_we && db_addr == 12'h000 && db_data != 32'd0 && db_data <= 32'(NUM_IDS))
      |=> pend[$past(db_data[IDW-1:0])]);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_sel == 12'h071 || ind_sel == 12'h000) |-> ind_rdata == 32'd0);
endmodule

bind msi_file msi_file_chk #(.NUM_IDS(NUM_IDS)) u_chk (.*);

// File: tb/sim_msi_file.sv
`timescale 1ns/1ps
module sim_msi_file;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        db_we = 1'b0, ind_we = 1'b0;
  logic [11:0] db_addr = '0, ind_sel = '0;
  logic [31:0] db_data = '0, ind_wdata = '0;
  logic [1:0]  ind_op = '0;
  logic [31:0] ind_rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  msi_file #(.NUM_IDS(63)) u0 (.*);

  // {req[63:60], kind[59:58] 0=doorbell 1=indirect, addr/sel[57:46], op[45:44],
  //  data[43:12], expected top id[11:1], expected irq[0]}
  localparam int NV = 20;
  localparam logic [63:0] VEC [NV] = '{
    {4'd2, 2'd0, 12'h000, 2'd0, 32'd5,          11'd5,  1'b1},  // R2 LE
    {4'd2, 2'd0, 12'h004, 2'd0, 32'h0300_0000,  11'd3,  1'b1},  // R2 BE
    {4'd7, 2'd0, 12'h000, 2'd0, 32'd40,         11'd3,  1'b1},  // R7 lowest wins
    {4'd8, 2'd1, 12'h076, 2'd0, 32'd0,          11'd5,  1'b1},  // R8 claim
    {4'd8, 2'd1, 12'h076, 2'd3, 32'd0,          11'd40, 1'b1},  // R8 claim op 11
    {4'd6, 2'd1, 12'h0C1, 2'd2, 32'h100,        11'd0,  1'b0},  // R6 clear enable 40
    {4'd6, 2'd1, 12'h0C1, 2'd1, 32'h100,        11'd40, 1'b1},  // R6 set enable 40
    {4'd4, 2'd1, 12'h072, 2'd0, 32'd40,         11'd0,  1'b0},  // R4 at threshold
    {4'd4, 2'd1, 12'h072, 2'd0, 32'd41,         11'd40, 1'b1},  // R4 below threshold
    {4'd4, 2'd1, 12'h072, 2'd0, 32'd0,          11'd40, 1'b1},  // R4 zero threshold
    {4'd2, 2'd0, 12'h000, 2'd0, 32'd0,          11'd40, 1'b1},  // R2 id 0 ignored
    {4'd2, 2'd0, 12'h000, 2'd0, 32'd64,         11'd40, 1'b1},  // R2 id 64 ignored
    {4'd2, 2'd0, 12'h008, 2'd0, 32'd2,          11'd40, 1'b1},  // R2 bad offset
    {4'd5, 2'd1, 12'h080, 2'd1, 32'd4,          11'd2,  1'b1},  // R5 pending via window
    {4'd3, 2'd1, 12'h070, 2'd0, 32'd0,          11'd2,  1'b0},  // R3 delivery off
    {4'd3, 2'd1, 12'h070, 2'd0, 32'd1,          11'd2,  1'b1},  // R3 delivery on
    {4'd2, 2'd0, 12'h000, 2'd0, 32'd63,         11'd2,  1'b1},  // R2 top id
    {4'd8, 2'd1, 12'h076, 2'd0, 32'd0,          11'd40, 1'b1},  // R8
    {4'd8, 2'd1, 12'h076, 2'd0, 32'd0,          11'd63, 1'b1},  // R8
    {4'd9, 2'd1, 12'h076, 2'd0, 32'd0,          11'd0,  1'b0}   // R9 irq drops
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic db(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); db_we = 1'b1; db_addr = a; db_data = d;
    @(negedge clk); db_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] s, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk); ind_we = 1'b1; ind_sel = s; ind_op = op; ind_wdata = d;
    @(negedge clk); ind_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] s, output logic [31:0] v);
    ind_sel = s; #1; v = ind_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 irq", {31'd0, irq}, 32'd0);
    rd(12'h070, v); check("R11 delivery", v, 0);
    rd(12'h072, v); check("R11 threshold", v, 0);
    rd(12'h076, v); check("R11 top", v, 0);
    rd(12'h080, v); check("R11 pending", v, 0);
    rd(12'h0C0, v); check("R11 enable", v, 0);

    wr(12'h070, 2'd0, 32'd1);
    rd(12'h070, v); check("R3 delivery readback", v, 32'd1);
    wr(12'h0C0, 2'd0, 32'hFFFF_FFFF);
    rd(12'h0C0, v); check("R1 enable bit 0", v, 32'hFFFF_FFFE);
    wr(12'h0C1, 2'd0, 32'hFFFF_FFFF);

    for (int n = 0; n < NV; n++) begin
      if (VEC[n][59:58] == 2'd0) db(VEC[n][57:46], VEC[n][43:12]);
      else wr(VEC[n][57:46], VEC[n][45:44], VEC[n][43:12]);
      rd(12'h076, v);
      check($sformatf("R%0d vector %0d top", VEC[n][63:60], n), v,
            VEC[n][11:1] == 11'd0 ? 32'd0 : {5'd0, VEC[n][11:1], 5'd0, VEC[n][11:1]});
      check($sformatf("R%0d vector %0d irq", VEC[n][63:60], n), {31'd0, irq},
            {31'd0, VEC[n][0]});
    end

    // R1 / R5 / R6 plain write and clear of a pending word
    wr(12'h080, 2'd0, 32'hFFFF_FFFF);
    rd(12'h080, v); check("R1 pending bit 0", v, 32'hFFFF_FFFE);
    rd(12'h076, v); check("R7 id 1 wins", v, 32'h0001_0001);
    wr(12'h080, 2'd2, 32'hFFFF_FFFE);
    rd(12'h080, v); check("R6 clear word", v, 32'd0);

    // R10 reserved selects
    wr(12'h082, 2'd0, 32'hFFFF_FFFF);
    rd(12'h082, v); check("R10 reserved read", v, 0);
    wr(12'h071, 2'd0, 32'hFFFF_FFFF);
    rd(12'h071, v); check("R10 reserved 071", v, 0);
    rd(12'h080, v); check("R10 pending untouched", v, 0);
    rd(12'h0C0, v); check("R10 enable untouched", v, 32'hFFFF_FFFE);
    rd(12'h072, v); check("R10 threshold untouched", v, 0);

    // R8 swap returns winner in claim cycle
    db(12'h000, 32'd7);
    @(negedge clk); ind_we = 1'b1; ind_sel = 12'h076; ind_op = 2'd0; #1;
    check("R8 swap value", ind_rdata, 32'h0007_0007);
    @(negedge clk); ind_we = 1'b0;
    rd(12'h076, v); check("R8 claimed", v, 0);
    check("R9 irq after claim", {31'd0, irq}, 0);

    // R8 doorbell colliding with claim of the same identity
    db(12'h000, 32'd7);
    @(negedge clk); ind_we = 1'b1; ind_sel = 12'h076; db_we = 1'b1; db_addr = 12'h000; db_data = 32'd7;
    @(negedge clk); ind_we = 1'b0; db_we = 1'b0;
    rd(12'h076, v); check("R8 doorbell beats claim", v, 32'h0007_0007);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule